// File: doc/BRIEF.md
# Interrupt and Stack Sequencer

This block carries out the memory traffic that an 8-bit processor core needs whenever control flow passes through the hardware stack: entering an interrupt, executing the software break, calling and returning from a subroutine, and returning from an interrupt. The core hands it a request code together with its current program counter, its status byte and, for a call, the target address. The sequencer then performs the stack pushes and pops and the vector fetches one byte per clock over a byte-wide synchronous memory port. When it finishes, it presents the new program counter, stack pointer and status byte together with a one-cycle `done` pulse.

A separate poll request asks the block to check the two interrupt pins. The non-maskable line wins over the maskable one. The maskable line waits while the interrupt-disable flag is set. A pin counts as requesting when its level differs from a recorded idle level, and that idle level is refreshed each time an interrupt is taken. Leaving reset, the block fetches the start address from the reset vector by itself.

Top module: `stk_seq`

## Requirements
- R1: A push writes to address 0x0100 + SP and then decrements SP. A pop first increments SP and then reads 0x0100 + SP. SP wraps within the page. Read data is returned on `mem_rdata` in the cycle after the address is presented.
- R2: A 16-bit push writes the high byte and then the low byte. A 16-bit pop reads the low byte and then the high byte.
- R3: Reset sets SP to 0xFF and the status byte to 0x22 (Z is bit 1; the always-one bit R is bit 5). The block then loads PC from 0xFFFC (low byte) and 0xFFFD (high byte), and `done` is visible after the third rising edge following reset release.
- R4: Poll (code 0) treats a pin as requesting when its level differs from its idle level; both idle levels reset to 1. A non-maskable request wins over a maskable one. A maskable request is taken only while I (bit 2) is clear, and it stays pending while it is masked. If nothing is taken, PC takes `pc_in`, the status byte takes `status_in`, and nothing is written.
- R5: Interrupt entry pushes `pc_in` and then the status byte with B (bit 4) forced to 0, and clears D (bit 3). Non-maskable entry vectors through 0xFFFA/0xFFFB. Maskable entry vectors through 0xFFFE/0xFFFF and also sets I.
- R6: Taking an interrupt records both current pin levels as the new idle levels, so a level that persists is not serviced again.
- R7: Break (code 4) pushes `pc_in` + 2 and then the status byte with B set to 1. It sets I, clears D and vectors through 0xFFFE/0xFFFF.
- R8: Return from interrupt (code 3) pops the status byte with bit 5 forced to 1, then pops PC.
- R9: Call (code 1) pushes `pc_in` + 2, the address of the last byte of the three-byte call, and sets PC to `call_target`. Return from subroutine (code 2) pops PC and adds one. Both set the status byte to `status_in`.
- R10: Codes 5 to 7 cause no memory write and leave PC, SP and the status byte unchanged, with `done` after the accepting edge.
- R11: Let E be the edge that accepts a request. `done` is a one-cycle pulse that is visible after edge E+k, where k is 0 for a poll with nothing taken or an unknown code, 3 for call and return from subroutine, 4 for return from interrupt, and 6 for interrupt entry and break. Requests that arrive while a sequence is running are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when the block is idle |
| req_code | input | 3 | 0 poll, 1 call, 2 return from subroutine, 3 return from interrupt, 4 break |
| pc_in | input | 16 | Current PC (next instruction for a poll, opcode address for call and break) |
| status_in | input | 8 | Current status byte |
| call_target | input | 16 | Jump target for a call |
| nmi_pin | input | 1 | Non-maskable interrupt line |
| irq_pin | input | 1 | Maskable interrupt line |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| pc_out | output | 16 | New program counter, valid with `done` |
| sp_out | output | 8 | Stack pointer |
| status_out | output | 8 | New status byte, valid with `done` |
| done | output | 1 | Sequence finished |

## Verification
The assertions check on every cycle that each write lands in the stack page at the current SP and is followed by a decrement. They also check that the pushed status byte carries B exactly for break, and that `done` never lasts two cycles. Other properties need whole scenarios and are shown only by the bench:

- byte order on the stack,
- vector addresses,
- interrupt priority and masking,
- refresh of the idle levels,
- the pop-side flag forcing and the +1 on subroutine return,
- SP wrap inside the page,
- the latency of each request.

// File: rtl/stk_seq_pkg.sv
`timescale 1ns/1ps
package stk_seq_pkg;

    // status byte bit positions (decoded by the core, so fixed)
    localparam int ST_C = 0;
    localparam int ST_Z = 1;
    localparam int ST_I = 2;
    localparam int ST_D = 3;
    localparam int ST_B = 4;
    localparam int ST_R = 5;

    // request codes
    localparam logic [2:0] RQ_POLL = 3'd0;
    localparam logic [2:0] RQ_CALL = 3'd1;
    localparam logic [2:0] RQ_RSUB = 3'd2;
    localparam logic [2:0] RQ_RINT = 3'd3;
    localparam logic [2:0] RQ_BRK  = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE, S_PUSH_HI, S_PUSH_LO, S_PUSH_ST,
        S_POP_ST, S_POP_LO, S_POP_HI, S_VEC_LO, S_VEC_HI, S_FIN
    } state_e;

    typedef enum logic [1:0] {CAP_NONE, CAP_ST, CAP_PCL, CAP_PCH} cap_e;

    typedef enum logic [2:0] {K_CALL, K_RSUB, K_RINT, K_BRK, K_NMI, K_IRQ, K_RST} kind_e;

    typedef enum logic [1:0] {V_NMI, V_RST, V_IRQ} vec_e;

    typedef enum logic [2:0] {A_NONE, A_PUSH, A_POP, A_VLO, A_VHI} aop_e;

    typedef struct packed {
        state_e      st;
        kind_e       kind;
        cap_e        cap;
        logic [15:0] pc;
        logic [15:0] push_val;
        logic [7:0]  sp;
        logic [7:0]  stat;
        logic        done;
    } regs_t;

endpackage

// File: rtl/stk_seq_arb.sv
`timescale 1ns/1ps
module stk_seq_arb #(
    parameter logic NMI_IDLE = 1'b1,
    parameter logic IRQ_IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_pin,
    input  logic irq_pin,
    input  logic mask_irq,
    input  logic poll,
    output logic take_nmi,
    output logic take_irq
);
    typedef struct packed {
        logic nmi;
        logic irq;
    } lvl_t;

    lvl_t lvl_d, lvl_q;
    logic nmi_pend, irq_pend;

    always_comb begin
        nmi_pend = (nmi_pin != lvl_q.nmi);
        irq_pend = (irq_pin != lvl_q.irq);
        take_nmi = poll && nmi_pend;
        take_irq = poll && !nmi_pend && irq_pend && !mask_irq;
        lvl_d    = lvl_q;
        if (take_nmi || take_irq) begin
            lvl_d.nmi = nmi_pin;
            lvl_d.irq = irq_pin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q.nmi <= NMI_IDLE;
            lvl_q.irq <= IRQ_IDLE;
        end else begin
            lvl_q <= lvl_d;
        end
    end
endmodule

// File: rtl/stk_seq_addr.sv
`timescale 1ns/1ps
module stk_seq_addr
    import stk_seq_pkg::*;
#(
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] VEC_NMI    = 16'hFFFA,
    parameter logic [15:0] VEC_RST    = 16'hFFFC,
    parameter logic [15:0] VEC_IRQ    = 16'hFFFE
) (
    input  aop_e        aop,
    input  vec_e        vsel,
    input  logic [7:0]  sp,
    output logic [15:0] addr,
    output logic [7:0]  sp_next
);
    logic [15:0] vbase;

    always_comb begin
        case (vsel)
            V_NMI:   vbase = VEC_NMI;
            V_RST:   vbase = VEC_RST;
            default: vbase = VEC_IRQ;
        endcase
        sp_next = sp;
        addr    = '0;
        case (aop)
            A_PUSH: begin
                addr    = {STACK_PAGE, sp};
                sp_next = sp - 8'd1;
            end
            A_POP: begin
                sp_next = sp + 8'd1;
                addr    = {STACK_PAGE, sp_next};
            end
            A_VLO:   addr = vbase;
            A_VHI:   addr = vbase + 16'd1;
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/stk_seq.sv
`timescale 1ns/1ps
module stk_seq
    import stk_seq_pkg::*;
#(
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] VEC_NMI    = 16'hFFFA,
    parameter logic [15:0] VEC_RST    = 16'hFFFC,
    parameter logic [15:0] VEC_IRQ    = 16'hFFFE,
    parameter logic [7:0]  SP_INIT    = 8'hFF,
    parameter logic [7:0]  ST_INIT    = 8'h22,
    parameter logic [15:0] CALL_ADV   = 16'd2,
    parameter logic [15:0] BRK_ADV    = 16'd2,
    parameter logic        NMI_IDLE   = 1'b1,
    parameter logic        IRQ_IDLE   = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [2:0]  req_code,
    input  logic [15:0] pc_in,
    input  logic [7:0]  status_in,
    input  logic [15:0] call_target,
    input  logic        nmi_pin,
    input  logic        irq_pin,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] pc_out,
    output logic [7:0]  sp_out,
    output logic [7:0]  status_out,
    output logic        done
);
    localparam regs_t RST_REGS = '{st: S_VEC_LO, kind: K_RST, cap: CAP_NONE,
                                   pc: '0, push_val: '0, sp: SP_INIT,
                                   stat: ST_INIT, done: 1'b0};

    regs_t r_d, r_q;
    aop_e  aop;
    vec_e  vsel;
    logic  [7:0] sp_next;
    logic  poll, take_nmi, take_irq;

    assign poll = req_valid && (r_q.st == S_IDLE) && (req_code == RQ_POLL);

    stk_seq_arb #(.NMI_IDLE(NMI_IDLE), .IRQ_IDLE(IRQ_IDLE)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_pin  (nmi_pin),
        .irq_pin  (irq_pin),
        .mask_irq (status_in[ST_I]),
        .poll     (poll),
        .take_nmi (take_nmi),
        .take_irq (take_irq)
    );

    stk_seq_addr #(.STACK_PAGE(STACK_PAGE), .VEC_NMI(VEC_NMI),
                   .VEC_RST(VEC_RST), .VEC_IRQ(VEC_IRQ)) u_addr (
        .aop     (aop),
        .vsel    (vsel),
        .sp      (r_q.sp),
        .addr    (mem_addr),
        .sp_next (sp_next)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.cap   = CAP_NONE;
        aop       = A_NONE;
        mem_we    = 1'b0;
        mem_wdata = '0;
        case (r_q.kind)
            K_NMI:   vsel = V_NMI;
            K_RST:   vsel = V_RST;
            default: vsel = V_IRQ;
        endcase

        // byte requested in the previous cycle arrives now
        case (r_q.cap)
            CAP_ST:  r_d.stat = mem_rdata | (8'd1 << ST_R);
            CAP_PCL: r_d.pc[7:0]  = mem_rdata;
            CAP_PCH: r_d.pc[15:8] = mem_rdata;
            default: ;
        endcase

        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    case (req_code)
                        RQ_CALL: begin
                            r_d.kind     = K_CALL;
                            r_d.push_val = pc_in + CALL_ADV;
                            r_d.pc       = call_target;
                            r_d.stat     = status_in;
                            r_d.st       = S_PUSH_HI;
                        end
                        RQ_RSUB: begin
                            r_d.kind = K_RSUB;
                            r_d.stat = status_in;
                            r_d.st   = S_POP_LO;
                        end
                        RQ_RINT: begin
                            r_d.kind = K_RINT;
                            r_d.st   = S_POP_ST;
                        end
                        RQ_BRK: begin
                            r_d.kind     = K_BRK;
                            r_d.push_val = pc_in + BRK_ADV;
                            r_d.stat     = status_in;
                            r_d.st       = S_PUSH_HI;
                        end
                        RQ_POLL: begin
                            r_d.stat     = status_in;
                            r_d.push_val = pc_in;
                            if (take_nmi) begin
                                r_d.kind = K_NMI;
                                r_d.st   = S_PUSH_HI;
                            end else if (take_irq) begin
                                r_d.kind = K_IRQ;
                                r_d.st   = S_PUSH_HI;
                            end else begin
                                r_d.pc   = pc_in;
                                r_d.done = 1'b1;
                            end
                        end
                        default: r_d.done = 1'b1;
                    endcase
                end
            end
            S_PUSH_HI: begin
                aop       = A_PUSH;
                mem_we    = 1'b1;
                mem_wdata = r_q.push_val[15:8];
                r_d.sp    = sp_next;
                r_d.st    = S_PUSH_LO;
            end
            S_PUSH_LO: begin
                aop       = A_PUSH;
                mem_we    = 1'b1;
                mem_wdata = r_q.push_val[7:0];
                r_d.sp    = sp_next;
                r_d.st    = (r_q.kind == K_CALL) ? S_FIN : S_PUSH_ST;
            end
            S_PUSH_ST: begin
                aop       = A_PUSH;
                mem_we    = 1'b1;
                mem_wdata = r_q.stat;
                mem_wdata[ST_B] = (r_q.kind == K_BRK);
                r_d.sp    = sp_next;
                r_d.stat[ST_D] = 1'b0;
                if (r_q.kind != K_NMI) begin
                    r_d.stat[ST_I] = 1'b1;
                end
                r_d.st    = S_VEC_LO;
            end
            S_POP_ST: begin
                aop     = A_POP;
                r_d.sp  = sp_next;
                r_d.cap = CAP_ST;
                r_d.st  = S_POP_LO;
            end
            S_POP_LO: begin
                aop     = A_POP;
                r_d.sp  = sp_next;
                r_d.cap = CAP_PCL;
                r_d.st  = S_POP_HI;
            end
            S_POP_HI: begin
                aop     = A_POP;
                r_d.sp  = sp_next;
                r_d.cap = CAP_PCH;
                r_d.st  = S_FIN;
            end
            S_VEC_LO: begin
                aop     = A_VLO;
                r_d.cap = CAP_PCL;
                r_d.st  = S_VEC_HI;
            end
            S_VEC_HI: begin
                aop     = A_VHI;
                r_d.cap = CAP_PCH;
                r_d.st  = S_FIN;
            end
            S_FIN: begin
                if (r_q.kind == K_RSUB) begin
                    r_d.pc = r_d.pc + 16'd1;
                end
                r_d.done = 1'b1;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST_REGS;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_out     = r_q.pc;
    assign sp_out     = r_q.sp;
    assign status_out = r_q.stat;
    assign done       = r_q.done;
endmodule

// File: rtl/stk_seq_chk.sv
`timescale 1ns/1ps
module stk_seq_chk
    import stk_seq_pkg::*;
#(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic [7:0]  sp_out,
    input logic        done,
    input state_e      state,
    input kind_e       kind
);
    AST_WRITE_IN_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[15:8] == STACK_PAGE); // R1
    AST_WRITE_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[7:0] == sp_out); // R1
    AST_WRITE_THEN_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_out == $past(sp_out) - 8'd1); // R1
    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_BREAK_PUSHES_B: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUSH_ST && kind == K_BRK) |-> (mem_we && mem_wdata[ST_B])); // R7
    AST_ENTRY_CLEARS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUSH_ST && kind != K_BRK) |-> (mem_we && !mem_wdata[ST_B])); // R5
endmodule

bind stk_seq stk_seq_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sp_out    (sp_out),
    .done      (done),
    .state     (r_q.st),
    .kind      (r_q.kind)
);

// File: tb/stk_seq_bench.sv
`timescale 1ns/1ps
module stk_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_code = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  status_in = '0;
    logic [15:0] call_target = '0;
    logic        nmi_pin = 1'b1;
    logic        irq_pin = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic [15:0] pc_out;
    logic [7:0]  sp_out;
    logic [7:0]  status_out;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    stk_seq u_stk_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .pc_in(pc_in), .status_in(status_in), .call_target(call_target),
        .nmi_pin(nmi_pin), .irq_pin(irq_pin), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .pc_out(pc_out), .sp_out(sp_out), .status_out(status_out), .done(done)
    );

    // memory model: stack page plus the vector bytes, registered read
    logic [7:0] stk [0:255];

    function automatic logic [7:0] vec_byte(input logic [2:0] i);
        case (i)
            3'd2: return 8'h00;  // 0xFFFA
            3'd3: return 8'h90;  // 0xFFFB
            3'd4: return 8'h00;  // 0xFFFC
            3'd5: return 8'h80;  // 0xFFFD
            3'd6: return 8'h00;  // 0xFFFE
            3'd7: return 8'hA0;  // 0xFFFF
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            stk[0] <= 8'h34;
            stk[1] <= 8'h12;
        end else if (mem_we && mem_addr[15:8] == 8'h01) begin
            stk[mem_addr[7:0]] <= mem_wdata;
        end
        if (mem_we) wr_cnt <= wr_cnt + 1;
        if (mem_addr[15:8] == 8'h01)      mem_rdata <= stk[mem_addr[7:0]];
        else if (mem_addr[15:3] == 13'h1FFF) mem_rdata <= vec_byte(mem_addr[2:0]);
        else                              mem_rdata <= 8'h00;
    end

    function automatic string tag_of(input logic [3:0] n);
        case (n)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] code, input logic nmi_v, input logic irq_v,
                       input logic [15:0] pc_v, input logic [7:0] st_v,
                       input logic [15:0] tg, output int lat, output int wrs);
        int w0;
        @(negedge clk);
        nmi_pin = nmi_v; irq_pin = irq_v; req_code = code;
        pc_in = pc_v; status_in = st_v; call_target = tg;
        req_valid = 1'b1;
        w0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        wrs = wr_cnt - w0;
    endtask

    typedef struct packed {
        logic [3:0]  tag;
        logic [2:0]  code;
        logic        nmi;
        logic        irq;
        logic [15:0] pc;
        logic [7:0]  st;
        logic [15:0] tgt;
        logic [15:0] e_pc;
        logic [7:0]  e_sp;
        logic [7:0]  e_st;
        logic [3:0]  e_lat;
        logic [3:0]  e_wr;
        logic        c_en;
        logic [7:0]  c_idx;
        logic [7:0]  c_val;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [0:NV-1] = '{
        '{4'd9,  3'd1, 1'b1, 1'b1, 16'h8010, 8'h22, 16'h8200, 16'h8200, 8'hFD, 8'h22, 4'd3, 4'd2, 1'b1, 8'hFE, 8'h12}, // R9 call
        '{4'd9,  3'd1, 1'b1, 1'b1, 16'h8205, 8'h22, 16'h8300, 16'h8300, 8'hFB, 8'h22, 4'd3, 4'd2, 1'b1, 8'hFC, 8'h07}, // R9 nested call
        '{4'd9,  3'd2, 1'b1, 1'b1, 16'h0000, 8'h23, 16'h0000, 16'h8208, 8'hFD, 8'h23, 4'd3, 4'd0, 1'b0, 8'h00, 8'h00}, // R9 return +1
        '{4'd9,  3'd2, 1'b1, 1'b1, 16'h0000, 8'h22, 16'h0000, 16'h8013, 8'hFF, 8'h22, 4'd3, 4'd0, 1'b0, 8'h00, 8'h00}, // R9
        '{4'd4,  3'd0, 1'b1, 1'b1, 16'h8020, 8'hA2, 16'h0000, 16'h8020, 8'hFF, 8'hA2, 4'd0, 4'd0, 1'b0, 8'h00, 8'h00}, // R4 nothing pending
        '{4'd4,  3'd0, 1'b1, 1'b0, 16'h8030, 8'h26, 16'h0000, 16'h8030, 8'hFF, 8'h26, 4'd0, 4'd0, 1'b0, 8'h00, 8'h00}, // R4 masked
        '{4'd5,  3'd0, 1'b1, 1'b0, 16'h8040, 8'h3A, 16'h0000, 16'hA000, 8'hFC, 8'h36, 4'd6, 4'd3, 1'b1, 8'hFD, 8'h2A}, // R5 maskable entry
        '{4'd6,  3'd0, 1'b1, 1'b0, 16'hA010, 8'h22, 16'h0000, 16'hA010, 8'hFC, 8'h22, 4'd0, 4'd0, 1'b0, 8'h00, 8'h00}, // R6 no re-entry
        '{4'd8,  3'd3, 1'b1, 1'b0, 16'hA020, 8'h00, 16'h0000, 16'h8040, 8'hFF, 8'h2A, 4'd4, 4'd0, 1'b0, 8'h00, 8'h00}, // R8
        '{4'd4,  3'd0, 1'b0, 1'b1, 16'h8050, 8'h2C, 16'h0000, 16'h9000, 8'hFC, 8'h24, 4'd6, 4'd3, 1'b1, 8'hFD, 8'h2C}, // R4 priority, R5
        '{4'd6,  3'd0, 1'b0, 1'b1, 16'h9010, 8'h20, 16'h0000, 16'h9010, 8'hFC, 8'h20, 4'd0, 4'd0, 1'b0, 8'h00, 8'h00}, // R6
        '{4'd7,  3'd4, 1'b0, 1'b1, 16'h9020, 8'h09, 16'h0000, 16'hA000, 8'hF9, 8'h05, 4'd6, 4'd3, 1'b1, 8'hFA, 8'h19}, // R7 break
        '{4'd8,  3'd3, 1'b0, 1'b1, 16'h0000, 8'h00, 16'h0000, 16'h9022, 8'hFC, 8'h39, 4'd4, 4'd0, 1'b1, 8'hFB, 8'h22}, // R8 bit 5 forced
        '{4'd8,  3'd3, 1'b0, 1'b1, 16'h0000, 8'h00, 16'h0000, 16'h8050, 8'hFF, 8'h2C, 4'd4, 4'd0, 1'b0, 8'h00, 8'h00}, // R8
        '{4'd10, 3'd7, 1'b0, 1'b1, 16'h1234, 8'h55, 16'h0000, 16'h8050, 8'hFF, 8'h2C, 4'd0, 4'd0, 1'b0, 8'h00, 8'h00}, // R10
        '{4'd1,  3'd2, 1'b0, 1'b1, 16'h0000, 8'h22, 16'h0000, 16'h1235, 8'h01, 8'h22, 4'd3, 4'd0, 1'b0, 8'h00, 8'h00}, // R1 wrap
        '{4'd2,  3'd1, 1'b0, 1'b1, 16'h1240, 8'h22, 16'h4000, 16'h4000, 8'hFF, 8'h22, 4'd3, 4'd2, 1'b1, 8'h00, 8'h42}  // R2 order
    };

    initial begin
        int lat;
        int wrs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check("R3", "reset latency", lat, 3);
        check("R3", "reset pc", pc_out, 16'h8000);
        check("R3", "reset sp", sp_out, 8'hFF);
        check("R3", "reset status", status_out, 8'h22);

        for (int i = 0; i < NV; i++) begin
            run(TBL[i].code, TBL[i].nmi, TBL[i].irq, TBL[i].pc, TBL[i].st, TBL[i].tgt, lat, wrs);
            check(tag_of(TBL[i].tag), $sformatf("vec %0d pc", i), pc_out, TBL[i].e_pc);
            check("R1", $sformatf("vec %0d sp", i), sp_out, TBL[i].e_sp);
            check(tag_of(TBL[i].tag), $sformatf("vec %0d status", i), status_out, TBL[i].e_st);
            check("R11", $sformatf("vec %0d latency", i), lat, TBL[i].e_lat);
            check(TBL[i].code > 3'd4 ? "R10" : "R2", $sformatf("vec %0d writes", i), wrs, TBL[i].e_wr);
            if (TBL[i].c_en)
                check("R2", $sformatf("vec %0d stack byte", i), stk[TBL[i].c_idx], TBL[i].c_val);
        end

        // R11: done lasts one cycle
        @(negedge clk);
        check("R11", "done width", done, 1'b0);

        // R11: requests during a running sequence are ignored
        begin
            int w0;
            @(negedge clk);
            req_code = 3'd1; pc_in = 16'h4000; call_target = 16'h5000; status_in = 8'h22;
            req_valid = 1'b1;
            w0 = wr_cnt;
            @(negedge clk);
            req_code = 3'd3;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            lat = 0;
            while (!done && lat < 40) begin
                @(negedge clk);
                lat++;
            end
            repeat (3) @(negedge clk);
            check("R11", "busy pc", pc_out, 16'h5000);
            check("R11", "busy sp", sp_out, 8'hFD);
            check("R11", "busy writes", wr_cnt - w0, 2);
            check("R9", "call hi byte", stk[8'hFF], 8'h40);
            check("R9", "call lo byte", stk[8'hFE], 8'h02);
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule